// File: doc/BRIEF.md
# Compare-Matched Up-Count Timer

An 8-bit up-counting timer built for a register-mapped peripheral space. Software programs a terminal value and a control word. The counter then advances on each count event until its value equals the terminal value. The count events come either from a free-running internal clock enable or from rising edges on an external pin.

On each match the block takes an action on a dedicated output pin. It can drive a programmed level, invert the pin, or leave the pin to general-purpose use with its driver off. It also latches a timeout flag that only software can clear, and it raises an interrupt request when that flag is set and interrupts are enabled.

The register interface is a single-cycle write strobe with a 2-bit address and a combinational read mux. There is no handshake. `rst_n` is asynchronous, active low, and must already be released synchronously to `clk`.

Top module: `upcount_timer`

## Requirements
- R1: After reset the control word, terminal value and counter are all 0, and `irq_o`, `pin_o` and `pin_oe_o` are 0.
- R2: Address 0 is the control word, laid out as {flag[7], irq_en[6], 0[5], run[4], action[3:2], source[1:0]}. Address 1 is the terminal value, which can be written but reads back as 0. Address 2 is the counter, which can be read and written. Address 3 reads 0. Bit 5 of the control word always reads 0.
- R3: While run (bit 4) is 0, the counter holds its value whatever count events arrive.
- R4: With source = 2'b11, each rising edge of `ext_cnt_i` counts once, after a two-stage synchronizer, and `tick_en_i` is ignored. With any other source value, each cycle with `tick_en_i` high counts once and `ext_cnt_i` is ignored.
- R5: Each count adds 1 to the counter. A count taken while the counter equals the terminal value reloads 0 instead. A match occurs on the count that makes the counter equal to the terminal value. With a terminal value of 0, every count is a match and the counter stays at 0.
- R6: Every match sets the flag (bit 7). The flag remains set through later counts. Writing the control word with bit 7 = 0 clears the flag, and writing it with bit 7 = 1 leaves the flag unchanged.
- R7: `irq_o` is high exactly when the flag and irq_en (bit 6) are both set.
- R8: With action = 2'b1x, a match drives `pin_o` to action bit 0 (control bit 2), and `pin_oe_o` is 1.
- R9: With action = 2'b01, a match inverts `pin_o`, and `pin_oe_o` is 1.
- R10: With action = 2'b00, `pin_oe_o` is 0 and a match leaves `pin_o` unchanged.
- R11: A write to the counter loads the written value in place of any count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en_i | input | 1 | Internal count enable, one count per high cycle |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| pin_o | output | 1 | Compare output level |
| pin_oe_o | output | 1 | Compare output drive enable |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following. The counter holds when no count or load is present. A match leaves the counter at the terminal value. A match sets the flag, and the flag falls only after a clearing write. A match with interrupts enabled raises the request. The pin is inverted in toggle mode, and it does not move between matches.

Only the directed scenarios can show the rest: the read-back layout of the registers, how the external and internal sources select and ignore each other, the wrap from the terminal value back to zero, the case of a zero terminal value, and the level and drive-enable results of each output action.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W = 8;

  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_LIMIT = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;

  localparam logic [1:0] SRC_EXT = 2'b11;

  typedef enum logic [1:0] {
    ACT_IO     = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = pin_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] count_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, cnt_d, inc;

  always_comb begin
    inc     = (cnt_q == limit_i) ? '0 : cnt_q + W'(1);
    match_o = step_i && !load_i && (inc == limit_i);
    cnt_d   = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (step_i) cnt_d = inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(count_o));
  assert_match_lands_on_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> (count_o == $past(limit_i)));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/tmr_pin_action.sv
module tmr_pin_action
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  act_e mode_i,
  output logic pin_o,
  output logic oe_o
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (match_i) begin
      unique case (mode_i)
        ACT_TOGGLE:        pin_d = ~pin_q;
        ACT_LOW, ACT_HIGH: pin_d = mode_i[0];
        default:           pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;
  assign oe_o  = (mode_i != ACT_IO);

  assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && mode_i == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));
  assert_pin_quiet_between_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !match_i |=> $stable(pin_o));
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W           = TMR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en_i,
  input  logic         ext_cnt_i,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         pin_o,
  output logic         pin_oe_o,
  output logic         irq_o
);
  localparam int unsigned CTL_W = 8;

  logic [1:0]   src_q, src_d;
  act_e         act_q, act_d;
  logic         run_q, run_d, ien_q, ien_d, flag_q, flag_d;
  logic [W-1:0] limit_q, limit_d, count;
  logic         wr_ctl, wr_limit, wr_count, ext_rise, step, match;
  logic [CTL_W-1:0] ctl_view;
  logic         unused_bit5;

  assign wr_ctl   = wr_en_i && (addr_i == ADDR_CTL);
  assign wr_limit = wr_en_i && (addr_i == ADDR_LIMIT);
  assign wr_count = wr_en_i && (addr_i == ADDR_COUNT);
  assign unused_bit5 = wdata_i[5];

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_cnt_i), .rise_o(ext_rise)
  );

  assign step = run_q && ((src_q == SRC_EXT) ? ext_rise : tick_en_i);

  tmr_count_core #(.W(W)) i_core (
    .clk(clk), .rst_n(rst_n), .step_i(step), .load_i(wr_count),
    .load_val_i(wdata_i), .limit_i(limit_q), .count_o(count), .match_o(match)
  );

  tmr_pin_action i_pin (
    .clk(clk), .rst_n(rst_n), .match_i(match), .mode_i(act_q),
    .pin_o(pin_o), .oe_o(pin_oe_o)
  );

  always_comb begin
    src_d   = src_q;
    act_d   = act_q;
    run_d   = run_q;
    ien_d   = ien_q;
    limit_d = limit_q;
    flag_d  = flag_q;
    if (wr_ctl) begin
      src_d = wdata_i[1:0];
      act_d = act_e'(wdata_i[3:2]);
      run_d = wdata_i[4];
      ien_d = wdata_i[6];
      if (!wdata_i[7]) flag_d = 1'b0;
    end
    if (wr_limit) limit_d = wdata_i;
    if (match) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      act_q   <= ACT_IO;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
      limit_q <= '0;
    end else begin
      src_q   <= src_d;
      act_q   <= act_d;
      run_q   <= run_d;
      ien_q   <= ien_d;
      flag_q  <= flag_d;
      limit_q <= limit_d;
    end
  end

  assign ctl_view = {flag_q, ien_q, 1'b0, run_q, act_q, src_q};

  always_comb begin
    unique case (addr_i)
      ADDR_CTL:   rdata_o = W'(ctl_view);
      ADDR_COUNT: rdata_o = count;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & ien_q;

  assert_match_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);
  assert_flag_clears_by_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_ctl && !wdata_i[7]));
  assert_match_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ien_q && !wr_ctl) |=> irq_o);
  assert_paused_no_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !match);
endmodule

// File: tb/test_upcount_timer.sv
module test_upcount_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, ext_cnt = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic       pin, pin_oe, irq;
  int         nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  upcount_timer i_upcount_timer (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .ext_cnt_i(ext_cnt),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_o(pin), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic ext_pulse(input int n);
    repeat (n) begin
      @(negedge clk); ext_cnt = 1'b1;
      repeat (4) @(negedge clk);
      ext_cnt = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("reg%0d", a), v, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1", 2'd0, 8'h00);
    chk_reg("R1", 2'd1, 8'h00);
    chk_reg("R1", 2'd2, 8'h00);
    chk("R1", "irq", {7'd0, irq}, 8'h00);
    chk("R1", "pin", {6'd0, pin_oe, pin}, 8'h00);
  endtask

  task automatic t_regs;
    wr(2'd1, 8'h05);
    chk_reg("R2", 2'd1, 8'h00);
    wr(2'd0, 8'h20);
    chk_reg("R2", 2'd0, 8'h00);
    chk_reg("R2", 2'd3, 8'h00);
  endtask

  task automatic t_pause;
    tick(3);
    chk_reg("R3", 2'd2, 8'h00);
  endtask

  task automatic t_fixed;
    wr(2'd0, 8'h1C);
    chk("R8", "oe/pin before", {6'd0, pin_oe, pin}, 8'h02);
    tick(4);
    chk_reg("R5", 2'd2, 8'h04);
    chk_reg("R6", 2'd0, 8'h1C);
    tick(1);
    chk_reg("R5", 2'd2, 8'h05);
    chk_reg("R6", 2'd0, 8'h9C);
    chk("R8", "pin high", {7'd0, pin}, 8'h01);
    tick(1);
    chk_reg("R5", 2'd2, 8'h00);
    wr(2'd0, 8'h18);
    chk_reg("R6", 2'd0, 8'h18);
    tick(5);
    chk("R8", "pin low", {6'd0, pin_oe, pin}, 8'h02);
    chk_reg("R6", 2'd0, 8'h98);
  endtask

  task automatic t_sticky;
    tick(2);
    chk_reg("R5", 2'd2, 8'h01);
    chk_reg("R6", 2'd0, 8'h98);
    wr(2'd0, 8'h98);
    chk_reg("R6", 2'd0, 8'h98);
    wr(2'd0, 8'h18);
    chk_reg("R6", 2'd0, 8'h18);
  endtask

  task automatic t_irq;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h58);
    tick(1);
    chk("R7", "irq before match", {7'd0, irq}, 8'h00);
    tick(1);
    chk("R7", "irq on match", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h98);
    chk("R7", "irq masked", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hD8);
    chk("R7", "irq unmasked", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h58);
    chk("R7", "irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_load;
    wr(2'd2, 8'h07);
    chk_reg("R11", 2'd2, 8'h07);
    tick(1);
    chk_reg("R11", 2'd2, 8'h08);
    chk_reg("R5", 2'd0, 8'h58);
  endtask

  task automatic t_toggle;
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h14);
    chk("R9", "oe/pin start", {6'd0, pin_oe, pin}, 8'h02);
    tick(1);
    chk("R9", "pin first", {7'd0, pin}, 8'h01);
    tick(1);
    chk("R9", "pin between", {7'd0, pin}, 8'h01);
    tick(1);
    chk("R9", "pin second", {7'd0, pin}, 8'h00);
  endtask

  task automatic t_release;
    wr(2'd0, 8'h10);
    chk("R10", "oe off", {7'd0, pin_oe}, 8'h00);
    tick(2);
    chk("R10", "pin held", {6'd0, pin_oe, pin}, 8'h00);
    chk_reg("R10", 2'd0, 8'h90);
  endtask

  task automatic t_ext;
    wr(2'd0, 8'h13);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    tick(3);
    chk_reg("R4", 2'd2, 8'h00);
    ext_pulse(3);
    chk_reg("R4", 2'd2, 8'h03);
    wr(2'd0, 8'h10);
    ext_pulse(2);
    chk_reg("R4", 2'd2, 8'h03);
    tick(1);
    chk_reg("R4", 2'd2, 8'h04);
  endtask

  task automatic t_zero_limit;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h10);
    tick(3);
    chk_reg("R5", 2'd2, 8'h00);
    chk_reg("R5", 2'd0, 8'h90);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pause();
    t_fixed();
    t_sticky();
    t_irq();
    t_load();
    t_toggle();
    t_release();
    t_ext();
    t_zero_limit();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule